// File: doc/BRIEF.md
# Iterative Shuffle Polar Encoder

This block turns a word of `N_BITS` message bits into a polar codeword. The codeword is c = uG over GF(2), where G is the n-fold Kronecker power of the 2x2 lower-triangular kernel [[1,0],[1,1]] and n = log2(`N_BITS`). The block has no unrolled butterfly network. It keeps one combinational stage and reuses it once per cycle for n cycles. The stage first splits the vector into its even-indexed entries and then its odd-indexed entries (a perfect shuffle). It then folds each adjacent pair. Because the shuffle is applied n times in all, the index rotation it causes cancels out, and the result comes out in natural order.

A producer offers a message word with `in_valid`. The word is taken on the edge where `in_ready` is also high. `in_ready` stays low while passes run. A one-cycle `done` pulse marks the cycle in which `cw` first holds the finished codeword. The codeword then stays on `cw` until the next word is accepted. A parameter selects either natural output order or bit-reversed output order. Frozen-bit choice and rate matching belong to the surrounding logic.

Top module: `polar_shuffle_enc`

## Requirements
- R1: After reset is released, `in_ready` is 1 and `done` is 0.
- R2: With `BITREV_OUT`=0, bit i of `in_word` is u_i and bit j of `cw` is c_j. Here c_j is the XOR of every u_i whose index i has a 1 in every bit position where j has a 1 (c = uG, G = [[1,0],[1,1]] to the n-th Kronecker power).
- R3: A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 for exactly n cycles.
- R4: `done` is 1 for exactly one cycle. That cycle follows the n-th rising edge after the accepting edge, which is the edge of the last pass.
- R5: While `in_ready` is 0, `in_valid` and `in_word` have no effect on the codeword that is being produced.
- R6: When no word is being accepted or encoded, `cw` keeps its value.
- R7: With `BITREV_OUT`=1, bit j of `cw` carries c_r, where r is j with its n index bits written in reverse order.
- R8: `in_ready` is 1 in the `done` cycle, so a new word can be accepted on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Message word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_word | input | N_BITS | Message bits, bit i is u_i |
| done | output | 1 | One-cycle pulse: codeword complete |
| cw | output | N_BITS | Codeword, held until the next acceptance |

## Verification
The assertions check the control timing on every cycle. They check that an accepted word starts a pass sequence at count zero, that the pass count stays in range, that the last pass always ends in a single `done` pulse, that an idle block holds `cw` steady, and that the output ordering stage preserves the number of ones. Only the bench scenarios can show that the codeword bits are the right GF(2) combinations: all 256 words at eight bits against a matrix multiply, plus a bit-reversed sixteen-bit instance. The bench scenarios also show that traffic offered while the block is busy is ignored, and that a word handed over in the `done` cycle is taken at once.

// File: rtl/polar_enc_pkg.sv
package polar_enc_pkg;

  // Reverse the low w bits of v.
  function automatic int unsigned rev_idx(input int unsigned v, input int unsigned w);
    int unsigned r;
    r = 0;
    for (int unsigned b = 0; b < w; b++) begin
      r = r | (((v >> b) & 1) << (w - 1 - b));
    end
    return r;
  endfunction

endpackage

// File: rtl/polar_rst_sync.sv
module polar_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/polar_shuffle_stage.sv
module polar_shuffle_stage #(
  parameter int N_BITS = 8
) (
  input  logic [N_BITS-1:0] x,
  output logic [N_BITS-1:0] y
);
  localparam int HALF = N_BITS / 2;

  logic [N_BITS-1:0] shuf;

  // Perfect shuffle: evens to the low half, odds to the high half,
  // then fold each adjacent pair.
  for (genvar k = 0; k < HALF; k++) begin : g_pair
    assign shuf[k]        = x[2*k];
    assign shuf[k + HALF] = x[2*k + 1];
    assign y[2*k]         = shuf[2*k] ^ shuf[2*k + 1];
    assign y[2*k + 1]     = shuf[2*k + 1];
  end
endmodule

// File: rtl/polar_out_order.sv
module polar_out_order
  import polar_enc_pkg::*;
#(
  parameter int N_BITS     = 8,
  parameter bit BITREV_OUT = 1'b0
) (
  input  logic [N_BITS-1:0] nat,
  output logic [N_BITS-1:0] ord
);
  localparam int IDX_W = $clog2(N_BITS);

  if (BITREV_OUT) begin : g_rev
    for (genvar j = 0; j < N_BITS; j++) begin : g_bit
      assign ord[j] = nat[rev_idx(j, IDX_W)];
    end
  end else begin : g_nat
    assign ord = nat;
  end
endmodule

// File: rtl/polar_pass_ctrl.sv
module polar_pass_ctrl #(
  parameter int NSTG = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (NSTG > 1) ? $clog2(NSTG) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NSTG - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  assert_start_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && cnt_q == '0 && !done_q));

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));

  assert_last_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> (done_q && !busy_q));

  assert_single_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/polar_shuffle_enc.sv
module polar_shuffle_enc #(
  parameter int N_BITS     = 8,
  parameter bit BITREV_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N_BITS-1:0] in_word,
  output logic              done,
  output logic [N_BITS-1:0] cw
);
  localparam int NSTG = $clog2(N_BITS);

  logic              rst_ns;
  logic              busy;
  logic              accept;
  logic              ld_en;
  logic [N_BITS-1:0] x_q, x_d;
  logic [N_BITS-1:0] stage_y;

  polar_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_ns)
  );

  polar_pass_ctrl #(.NSTG(NSTG)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_ns),
    .start (accept),
    .busy  (busy),
    .done  (done)
  );

  polar_shuffle_stage #(.N_BITS(N_BITS)) u_stage (
    .x (x_q),
    .y (stage_y)
  );

  polar_out_order #(.N_BITS(N_BITS), .BITREV_OUT(BITREV_OUT)) u_order (
    .nat (x_q),
    .ord (cw)
  );

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;
  assign ld_en    = accept | busy;

  always_comb begin
    x_d = x_q;
    if (accept) begin
      x_d = in_word;
    end else if (busy) begin
      x_d = stage_y;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      x_q <= '0;
    end else if (ld_en) begin
      x_q <= x_d;
    end
  end

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (!busy && !in_valid) |=> $stable(cw));

  assert_order_weight_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    $countones(cw) == $countones(x_q));
endmodule

// File: tb/polar_shuffle_enc_bench.sv
module polar_shuffle_enc_bench;
  localparam int NB8  = 8;
  localparam int NS8  = 3;
  localparam int NB16 = 16;
  localparam int NS16 = 4;

  localparam logic [7:0] STIM [10] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5,
                                       8'h5A, 8'h3C, 8'h0F, 8'hF0, 8'h69};

  logic clk;
  logic rst_n;
  logic in_valid, in_ready, done;
  logic [NB8-1:0] in_word, cw;
  logic v2, r2, d2;
  logic [NB16-1:0] w2, c2;

  int checks;
  int errors;

  polar_shuffle_enc #(.N_BITS(NB8), .BITREV_OUT(1'b0)) u_polar_shuffle_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .done(done), .cw(cw)
  );

  polar_shuffle_enc #(.N_BITS(NB16), .BITREV_OUT(1'b1)) u_polar_shuffle_enc_rev (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_ready(r2),
    .in_word(w2), .done(d2), .cw(c2)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Generator entry as a product of kernel entries, one per index bit.
  function automatic logic gen_bit(input int i, input int j, input int nst);
    logic g;
    g = 1'b1;
    for (int b = 0; b < nst; b++) begin
      if (((i >> b) & 1) == 0 && ((j >> b) & 1) == 1) g = 1'b0;
    end
    return g;
  endfunction

  function automatic logic [15:0] ref_enc(input logic [15:0] u, input int nb, input int nst);
    logic [15:0] c;
    c = '0;
    for (int j = 0; j < nb; j++) begin
      for (int i = 0; i < nb; i++) begin
        c[j] = c[j] ^ (u[i] & gen_bit(i, j, nst));
      end
    end
    return c;
  endfunction

  function automatic logic [15:0] rev_word(input logic [15:0] c, input int nb, input int nst);
    logic [15:0] o;
    o = '0;
    for (int j = 0; j < nb; j++) begin
      int r;
      r = 0;
      for (int b = 0; b < nst; b++) r = r | (((j >> b) & 1) << (nst - 1 - b));
      o[j] = c[r];
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge of the done cycle.
  task automatic run8(input logic [7:0] u, input bit noise);
    check("R8 ready before offer", 16'(in_ready), 16'h1);
    in_valid = 1'b1;
    in_word  = u;
    for (int k = 0; k <= NS8; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) begin
        if (noise) in_word = ~u;
        else in_valid = 1'b0;
      end
      if (k == NS8 - 1) in_valid = 1'b0;
      if (k < NS8) begin
        check("R3 ready low while encoding", 16'(in_ready), 16'h0);
        check("R4 done low before last pass", 16'(done), 16'h0);
      end else begin
        check("R4 done after last pass", 16'(done), 16'h1);
        check("R8 ready in done cycle", 16'(in_ready), 16'h1);
        check(noise ? "R5 busy traffic ignored" : "R2 codeword",
              16'(cw), ref_enc(16'(u), NB8, NS8));
      end
    end
  endtask

  task automatic run16(input logic [15:0] u);
    v2 = 1'b1;
    w2 = u;
    for (int k = 0; k <= NS16; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) v2 = 1'b0;
      if (k < NS16) check("R4 wide done low", 16'(d2), 16'h0);
      else begin
        check("R4 wide done", 16'(d2), 16'h1);
        check("R7 bit-reversed codeword", c2, rev_word(ref_enc(u, NB16, NS16), NB16, NS16));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    checks   = 0;
    errors   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    v2       = 1'b0;
    w2       = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready after reset", 16'(in_ready), 16'h1);
    check("R1 done after reset", 16'(done), 16'h0);
    check("R1 wide ready after reset", 16'(r2), 16'h1);

    // Table walk.
    for (int t = 0; t < 10; t++) begin
      run8(STIM[t], 1'b0);
      @(negedge clk);
    end

    // Directed corners: single message bits.
    run8(8'h01, 1'b0);
    check("R2 u0 alone reaches c0 only", 16'(cw), 16'h0001);
    @(negedge clk);
    run8(8'h80, 1'b0);
    check("R2 u7 alone reaches every output", 16'(cw), 16'h00FF);

    // Back-to-back acceptance in the done cycle.
    run8(8'h3C, 1'b0);
    run8(8'hC3, 1'b0);

    // Traffic offered while busy.
    @(negedge clk);
    run8(8'h96, 1'b1);

    // Hold after completion.
    held = cw;
    repeat (4) @(negedge clk);
    check("R6 codeword held while idle", 16'(cw), 16'(held));
    check("R4 done stays low while idle", 16'(done), 16'h0);

    // Exhaustive sweep at eight bits.
    for (int v = 0; v < 256; v++) begin
      run8(8'(v), 1'b0);
    end

    // Bit-reversed wide instance.
    run16(16'h0001);
    run16(16'h8000);
    run16(16'hBEEF);
    run16(16'h1234);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule